// File: doc/BRIEF.md
# Cartridge ROM/SRAM Address Translator

This block sits between the console's 24-bit bus address (8-bit bank, 16-bit offset) and a cartridge's storage. Each address it decodes produces exactly one of three results. The first is a ROM hit with a linear offset into a contiguous ROM image. The second is an SRAM hit with an offset that wraps at the SRAM size. The third is a no-response indication, which means the cartridge must leave the bus alone.

Two layouts are supported and chosen by a static input. The 32 KB-bank layout uses only the upper half of most banks and packs those halves back to back. The 64 KB-bank layout uses whole banks and drops the top two bank bits, which produces mirrors. Parameters set the SRAM size (a power of two from 2 bytes to 32 KB, or zero for none) and decide whether the low halves of the middle banks in 32 KB mode are ROM or unmapped.

The translation is registered. When the clock enable is high, the result for the address presented at a rising edge appears on the outputs just after that edge. When the enable is low, the outputs hold.

Top module: `cart_addr_xlat`

## Requirements
- R1: While reset is asserted and until the first enabled edge, rom_hit and sram_hit are 0, no_resp is 1, and both offsets are 0.
- R2: After an edge with en=1, exactly one of rom_hit, sram_hit and no_resp is 1, and it reflects the address and map_64k sampled at that edge.
- R3: After an edge with en=0, every output keeps its previous value.
- R4: With map_64k=0, offsets 8000-FFFF of every bank other than 7E and 7F give a ROM hit with rom_off = {bank[6:0], addr[14:0]}. Bank bit 7 is ignored, so 80:8000 gives the same offset as 00:8000.
- R5: With map_64k=0, offsets 0000-7FFF of banks 70-7D and F0-FF give an SRAM hit with sram_off = addr[14:0] modulo the SRAM size.
- R6: With map_64k=0, offsets 0000-7FFF of banks 40-6F and C0-EF give no response when LOW_HALF_ROM=0. When LOW_HALF_ROM=1 they give a ROM hit at the same offset that the upper half of the bank would give.
- R7: With map_64k=0, offsets 0000-7FFF of banks 00-3F and 80-BF give no response.
- R8: With map_64k=1, a ROM hit has rom_off = {bank[5:0], addr[15:0]}. Banks 00-3F and 80-BF hit ROM only at offsets 8000-FFFF.
- R9: With map_64k=1, banks 40-7D and C0-FF hit ROM at every offset.
- R10: With map_64k=1, offsets 6000-7FFF of banks 20-3F and A0-BF give an SRAM hit with sram_off = {bank[4:0], addr[12:0]} modulo the SRAM size. All other offsets below 8000 in banks 00-3F and 80-BF give no response.
- R11: Banks 7E and 7F give no response in both modes.
- R12: With SRAM_BYTES=0, each SRAM region gives no response, except in 32 KB mode with LOW_HALF_ROM=1, where it gives a ROM hit at the offset of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable for the result register |
| map_64k | input | 1 | Layout select: 0 = 32 KB banks, 1 = 64 KB banks |
| bus_addr | input | 24 | Console address, bank in bits 23:16 |
| rom_hit | output | 1 | Address decodes to ROM |
| rom_off | output | 22 | Linear ROM offset |
| sram_hit | output | 1 | Address decodes to SRAM |
| sram_off | output | SRAM_AW | SRAM offset, wrapped at the SRAM size |
| no_resp | output | 1 | Cartridge must not respond |

## Verification
The assertions assume that map_64k and bus_addr are at known levels at every enabled edge after reset. They also assume that en is driven low for the whole of reset. They rely on the SRAM size being a power of two no larger than 32 KB. The bench drives en and map_64k low from time zero, changes inputs only just after a rising edge, and uses only the sizes 8 KB and zero. Because of this, every property sees settled, legal inputs.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int ADDR_W     = 24;
  localparam int ROM_AW     = 22;
  localparam int SRAM_RAW_W = 18;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_SRAM = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e                  tgt;
    logic [ROM_AW-1:0]     rom_off;
    logic [SRAM_RAW_W-1:0] sram_raw;
  } dec_t;
endpackage

// File: rtl/cm_reset_sync.sv
module cm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/cm_dec_32k.sv
module cm_dec_32k
  import cart_map_pkg::*;
#(
  parameter bit SRAM_EN      = 1'b1,
  parameter bit LOW_HALF_ROM = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [6:0]  bank7;
  logic [15:0] ofs;
  logic        is_wram;
  logic        sram_bank;
  logic        mid_bank;

  always_comb begin
    bank7     = addr[22:16];
    ofs       = addr[15:0];
    // banks 7E/7F are work RAM only when bank bit 7 is clear
    is_wram   = !addr[23] && (bank7[6:1] == 6'h3F);
    sram_bank = (bank7[6:4] == 3'b111);
    mid_bank  = bank7[6] && !sram_bank;

    dec.rom_off  = {bank7, ofs[14:0]};
    dec.sram_raw = {3'b000, ofs[14:0]};
    dec.tgt      = TGT_NONE;

    if (is_wram) begin
      dec.tgt = TGT_NONE;
    end else if (ofs[15]) begin
      dec.tgt = TGT_ROM;
    end else if (sram_bank) begin
      if (SRAM_EN)           dec.tgt = TGT_SRAM;
      else if (LOW_HALF_ROM) dec.tgt = TGT_ROM;
    end else if (mid_bank && LOW_HALF_ROM) begin
      dec.tgt = TGT_ROM;
    end
  end
endmodule

// File: rtl/cm_dec_64k.sv
module cm_dec_64k
  import cart_map_pkg::*;
#(
  parameter bit SRAM_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [7:0]  bank;
  logic [15:0] ofs;
  logic        is_wram;
  logic        sram_win;

  always_comb begin
    bank     = addr[23:16];
    ofs      = addr[15:0];
    is_wram  = !bank[7] && (bank[6:1] == 6'h3F);
    sram_win = !bank[6] && bank[5] && (ofs[15:13] == 3'b011);

    dec.rom_off  = {bank[5:0], ofs};
    dec.sram_raw = {bank[4:0], ofs[12:0]};
    dec.tgt      = TGT_NONE;

    if (is_wram) begin
      dec.tgt = TGT_NONE;
    end else if (bank[6] || ofs[15]) begin
      dec.tgt = TGT_ROM;
    end else if (sram_win && SRAM_EN) begin
      dec.tgt = TGT_SRAM;
    end
  end
endmodule

// File: rtl/cm_sram_wrap.sv
module cm_sram_wrap
  import cart_map_pkg::*;
#(
  parameter int SRAM_AW = 13,
  parameter bit SRAM_EN = 1'b1
) (
  input  logic [SRAM_RAW_W-1:0] raw,
  output logic [SRAM_AW-1:0]    wrapped
);
  generate
    if (SRAM_EN) begin : g_wrap
      // power-of-two size: wrapping keeps the low address bits
      assign wrapped = raw[SRAM_AW-1:0];
    end else begin : g_none
      assign wrapped = '0;
    end
  endgenerate
endmodule

// File: rtl/cart_addr_xlat.sv
module cart_addr_xlat
  import cart_map_pkg::*;
#(
  parameter int SRAM_BYTES   = 8192,
  parameter bit LOW_HALF_ROM = 1'b0,
  localparam bit SRAM_EN     = (SRAM_BYTES > 0),
  localparam int SRAM_AW     = (SRAM_BYTES > 1) ? $clog2(SRAM_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               map_64k,
  input  logic [23:0]        bus_addr,
  output logic               rom_hit,
  output logic [21:0]        rom_off,
  output logic               sram_hit,
  output logic [SRAM_AW-1:0] sram_off,
  output logic               no_resp
);
  logic rst_q_n;
  dec_t dec_lo;
  dec_t dec_hi;
  dec_t dec_sel;
  logic [SRAM_AW-1:0] sram_w;

  logic               rom_hit_d, sram_hit_d, no_resp_d;
  logic [21:0]        rom_off_d;
  logic [SRAM_AW-1:0] sram_off_d;

  cm_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  cm_dec_32k #(.SRAM_EN(SRAM_EN), .LOW_HALF_ROM(LOW_HALF_ROM)) u_dec32 (
    .addr(bus_addr), .dec(dec_lo));

  cm_dec_64k #(.SRAM_EN(SRAM_EN)) u_dec64 (
    .addr(bus_addr), .dec(dec_hi));

  assign dec_sel = map_64k ? dec_hi : dec_lo;

  cm_sram_wrap #(.SRAM_AW(SRAM_AW), .SRAM_EN(SRAM_EN)) u_wrap (
    .raw(dec_sel.sram_raw), .wrapped(sram_w));

  // next-state
  always_comb begin
    rom_hit_d  = rom_hit;
    sram_hit_d = sram_hit;
    no_resp_d  = no_resp;
    rom_off_d  = rom_off;
    sram_off_d = sram_off;
    if (en) begin
      rom_hit_d  = (dec_sel.tgt == TGT_ROM);
      sram_hit_d = (dec_sel.tgt == TGT_SRAM);
      no_resp_d  = (dec_sel.tgt == TGT_NONE);
      rom_off_d  = (dec_sel.tgt == TGT_ROM)  ? dec_sel.rom_off : '0;
      sram_off_d = (dec_sel.tgt == TGT_SRAM) ? sram_w          : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rom_hit  <= 1'b0;
      sram_hit <= 1'b0;
      no_resp  <= 1'b1;
      rom_off  <= '0;
      sram_off <= '0;
    end else begin
      rom_hit  <= rom_hit_d;
      sram_hit <= sram_hit_d;
      no_resp  <= no_resp_d;
      rom_off  <= rom_off_d;
      sram_off <= sram_off_d;
    end
  end
endmodule

// File: rtl/cart_addr_xlat_chk.sv
module cart_addr_xlat_chk #(
  parameter int SRAM_BYTES = 8192,
  parameter int SRAM_AW    = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               map_64k,
  input logic [23:0]        bus_addr,
  input logic               rom_hit,
  input logic [21:0]        rom_off,
  input logic               sram_hit,
  input logic [SRAM_AW-1:0] sram_off,
  input logic               no_resp
);
  logic in_wram;
  assign in_wram = !bus_addr[23] && (bus_addr[22:17] == 6'h3F);

  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_hit, sram_hit, no_resp}) == 1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rom_hit) && $stable(sram_hit) && $stable(no_resp)
             && $stable(rom_off) && $stable(sram_off)));

  p_rom32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !map_64k && bus_addr[15] && !in_wram)
    |=> (rom_hit && rom_off == $past({bus_addr[22:16], bus_addr[14:0]})));

  p_sys_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !map_64k && !bus_addr[15] && !bus_addr[22]) |=> no_resp);

  p_rom64_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && map_64k && bus_addr[15] && !in_wram)
    |=> (rom_hit && rom_off == $past(bus_addr[21:0])));

  p_sram64_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && map_64k && !bus_addr[22] && bus_addr[21] && bus_addr[15:13] == 3'b011)
    |=> (sram_hit == (SRAM_BYTES > 0)));

  p_wram_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_wram) |=> no_resp);
endmodule

bind cart_addr_xlat cart_addr_xlat_chk #(.SRAM_BYTES(SRAM_BYTES), .SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .en(en), .map_64k(map_64k), .bus_addr(bus_addr),
  .rom_hit(rom_hit), .rom_off(rom_off), .sram_hit(sram_hit), .sram_off(sram_off),
  .no_resp(no_resp));

// File: tb/tb_cart_addr_xlat.sv
module tb_cart_addr_xlat;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic        map_64k;
  logic [23:0] bus_addr;

  logic        rom_hit, sram_hit, no_resp;
  logic [21:0] rom_off;
  logic [12:0] sram_off;
  logic        a_rom_hit, a_sram_hit, a_no_resp;
  logic [21:0] a_rom_off;
  logic [0:0]  a_sram_off;

  int n_chk;
  int n_bad;

  cart_addr_xlat dut (
    .clk(clk), .rst_n(rst_n), .en(en), .map_64k(map_64k), .bus_addr(bus_addr),
    .rom_hit(rom_hit), .rom_off(rom_off), .sram_hit(sram_hit),
    .sram_off(sram_off), .no_resp(no_resp));

  cart_addr_xlat #(.SRAM_BYTES(0), .LOW_HALF_ROM(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .en(en), .map_64k(map_64k), .bus_addr(bus_addr),
    .rom_hit(a_rom_hit), .rom_off(a_rom_off), .sram_hit(a_sram_hit),
    .sram_off(a_sram_off), .no_resp(a_no_resp));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // kind: 0 none, 1 rom, 2 sram
  task automatic expect_main(string req, int kind, int off);
    check(req, "flags", {rom_hit, sram_hit, no_resp},
          (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 : 3'b001);
    if (kind == 1) check(req, "rom_off", rom_off, off);
    if (kind == 2) check(req, "sram_off", sram_off, off);
  endtask

  task automatic expect_alt(string req, int kind, int off);
    check(req, "alt flags", {a_rom_hit, a_sram_hit, a_no_resp},
          (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 : 3'b001);
    if (kind == 1) check(req, "alt rom_off", a_rom_off, off);
  endtask

  // present one address with en=1; result is checked 1 ns after the capture edge
  task automatic xact(logic m64, logic [23:0] a);
    map_64k  = m64;
    bus_addr = a;
    en       = 1'b1;
    @(posedge clk);
    #1;
    en = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    check("R1", "flags in reset", {rom_hit, sram_hit, no_resp}, 3'b001);
    check("R1", "rom_off in reset", rom_off, 0);
    check("R1", "sram_off in reset", sram_off, 0);
  endtask

  task automatic t_rom32();
    xact(1'b0, 24'h008000); expect_main("R4", 1, 'h000000);
    xact(1'b0, 24'h018123); expect_main("R4", 1, 'h008123);
    xact(1'b0, 24'h808000); expect_main("R4", 1, 'h000000);
    xact(1'b0, 24'h7DFFFF); expect_main("R4", 1, 'h3EFFFF);
    xact(1'b0, 24'hFF8000); expect_main("R4", 1, 'h3F8000);
  endtask

  task automatic t_sram32();
    xact(1'b0, 24'h701234); expect_main("R5", 2, 'h1234);
    xact(1'b0, 24'h717ABC); expect_main("R5", 2, 'h1ABC);
    xact(1'b0, 24'hFE0010); expect_main("R5", 2, 'h0010);
    expect_alt("R12", 1, 'h3F0010);
    xact(1'b0, 24'h701234); expect_alt("R12", 1, 'h381234);
  endtask

  task automatic t_low32();
    xact(1'b0, 24'h451234); expect_main("R6", 0, 0);
    expect_alt("R6", 1, 'h229234);
    xact(1'b0, 24'hC00000); expect_main("R6", 0, 0);
    expect_alt("R6", 1, 'h200000);
    xact(1'b0, 24'h3F0000); expect_main("R7", 0, 0);
    expect_alt("R7", 0, 0);
    xact(1'b0, 24'h801FFF); expect_main("R7", 0, 0);
  endtask

  task automatic t_rom64();
    xact(1'b1, 24'h008000); expect_main("R8", 1, 'h008000);
    xact(1'b1, 24'h001000); expect_main("R8", 0, 0);
    xact(1'b1, 24'hBF9ABC); expect_main("R8", 1, 'h3F9ABC);
    xact(1'b1, 24'h410123); expect_main("R9", 1, 'h010123);
    xact(1'b1, 24'hC0FFFF); expect_main("R9", 1, 'h00FFFF);
    xact(1'b1, 24'hFF0000); expect_main("R9", 1, 'h3F0000);
    xact(1'b1, 24'h406000); expect_main("R9", 1, 'h006000);
  endtask

  task automatic t_sram64();
    xact(1'b1, 24'h206000); expect_main("R10", 2, 'h0000);
    expect_alt("R12", 0, 0);
    xact(1'b1, 24'h217FFF); expect_main("R10", 2, 'h1FFF);
    xact(1'b1, 24'h3F6005); expect_main("R10", 2, 'h0005);
    xact(1'b1, 24'hA06001); expect_main("R10", 2, 'h0001);
    xact(1'b1, 24'h205FFF); expect_main("R10", 0, 0);
    xact(1'b1, 24'h106000); expect_main("R10", 0, 0);
  endtask

  task automatic t_wram();
    xact(1'b0, 24'h7E8000); expect_main("R11", 0, 0);
    xact(1'b0, 24'h7F0000); expect_main("R11", 0, 0);
    xact(1'b1, 24'h7E0000); expect_main("R11", 0, 0);
    xact(1'b1, 24'h7FFFFF); expect_main("R11", 0, 0);
    expect_alt("R11", 0, 0);
  endtask

  task automatic t_hold();
    xact(1'b0, 24'h018123); expect_main("R2", 1, 'h008123);
    map_64k  = 1'b0;
    bus_addr = 24'h3F0000;
    en       = 1'b0;
    @(posedge clk);
    #1;
    expect_main("R3", 1, 'h008123);
    @(posedge clk);
    #1;
    expect_main("R3", 1, 'h008123);
    xact(1'b0, 24'h3F0000); expect_main("R2", 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    en       = 1'b0;
    map_64k  = 1'b0;
    bus_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_rom32();
    t_sram32();
    t_low32();
    t_rom64();
    t_sram64();
    t_wram();
    t_hold();
    finish_up();
  end
endmodule